// File: doc/BRIEF.md
# Power-Down and Session-Start Gating Controller

This block decides when a smart-card interface may be put to sleep, when it may wake, and when a host request may start a card session. It watches a power-down request, a card-presence line, a host run/stop bit and two supply-fault flags. From these it drives three things: a low-power enable for the analog domain, a session activate level with a one-cycle-or-longer deactivate command, and an interrupt line.

After power-down is released, a counter times a stabilization window. The block is ready only when that window has closed. A run request is taken only as a low-to-high transition seen while the block is ready. A transition that arrives while asleep or during the window is lost for good, so the host must toggle the bit low and high again. Either supply fault tears a session down at once. The interrupt follows card presence while asleep and while ready, so once the window ends it also serves as a ready indication.

The controller is a four-state machine:
- `ST_DOWN`: asleep, analog disabled.
- `ST_WAKE`: stabilizing.
- `ST_IDLE`: ready, no session.
- `ST_LIVE`: session active.

Its transitions are:
- DOWN→WAKE on release of power-down.
- WAKE→DOWN on a renewed request.
- WAKE→IDLE when the window expires.
- IDLE→DOWN on a request.
- IDLE→LIVE on a qualified rising run edge.
- LIVE→IDLE on a falling run edge or a fault.

Reset places the machine in `ST_WAKE` with a full window.

Top module: `cardpwr_gate`

## Requirements
- R1: While reset is held and on leaving reset, `analog_off_o`, `act_o` and `deact_o` are 0, and the block sits in a full stabilization window, so `irq_o` stays 0 for STAB_CYCLES cycles.
- R2: `analog_off_o` is 1 exactly while the block is in the power-down state. With no session, a high `pd_req_i` enters that state on the third clock edge after it changes, counting two synchronizer edges and the state edge.
- R3: After power-down is released, the window lasts STAB_CYCLES cycles. A renewed request during the window returns the block to power-down, and the next release restarts a full window.
- R4: A rising `host_run_i` seen during power-down or the window is dropped, and `act_o` stays 0. When a request and a rising edge arrive in the same ready cycle, power-down wins and the edge is dropped.
- R5: A `host_run_i` level that is already 1 when the window closes does not start a session. A fresh 0-to-1 transition is required.
- R6: In the ready state with no fault, a 0-to-1 change of `host_run_i` sets `act_o` to 1 on the third clock edge after the change, and not before.
- R7: A 1-to-0 change of `host_run_i` during a session clears `act_o` and raises `deact_o` for one cycle, both on the third clock edge after the change.
- R8: A 1 on `vdd_fault_i` or `vcc_fault_i` holds `deact_o` at 1 from the second edge after it appears, ends any session one edge later, and blocks session starts while present.
- R9: A power-down request made during a session is ignored (`analog_off_o` stays 0). Once the session ends, the block enters power-down if the request is still present.
- R10: `irq_o` equals the synchronized `card_here_i` in the power-down, ready and session states, and is 0 during the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_i | input | 1 | Power-down request, active high, asynchronous |
| card_here_i | input | 1 | Card present, active high, asynchronous |
| host_run_i | input | 1 | Host run/stop bit, edge-qualified, asynchronous |
| vdd_fault_i | input | 1 | Logic-supply fault flag, asynchronous |
| vcc_fault_i | input | 1 | Card-supply fault flag, asynchronous |
| analog_off_o | output | 1 | Low-power enable for the analog domain |
| act_o | output | 1 | Session activate level for the card sequencer |
| deact_o | output | 1 | Deactivate command (end pulse or fault level) |
| irq_o | output | 1 | Interrupt: card present, or ready with a card present |

## Verification
Three pairs of events can land in the same cycle and are driven onto the same clock edge on purpose.

- A falling run edge and a supply fault together must produce a single teardown, with `deact_o` high and no second activation.
- A power-down request and a rising run edge arriving together while ready must end in power-down with the edge lost.
- A rising run level that is already high as the window expires must not count as an edge.

A behavioural reference model tracks the synchronizer delay and the window count. It judges every output on every cycle, alongside targeted checks at the edges predicted for each collision.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
    typedef enum logic [1:0] {
        ST_DOWN = 2'd0,
        ST_WAKE = 2'd1,
        ST_IDLE = 2'd2,
        ST_LIVE = 2'd3
    } cpg_state_t;

    localparam int IN_W   = 5;
    localparam int I_PD   = 0;
    localparam int I_RUN  = 1;
    localparam int I_CARD = 2;
    localparam int I_VDDF = 3;
    localparam int I_VCCF = 4;
endpackage

// File: rtl/cpg_sync.sv
module cpg_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            hold_q <= '0;
        end else begin
            meta_q <= d_i;
            hold_q <= meta_q;
        end
    end

    assign q_o = hold_q;
endmodule

// File: rtl/cpg_stab_timer.sv
module cpg_stab_timer #(
    parameter int STAB_CYCLES = 2_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload_i,
    output logic expired_o
);
    localparam int CW = $clog2(STAB_CYCLES) + 1;
    localparam logic [CW-1:0] TOP = CW'(STAB_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= TOP;
        end else if (reload_i) begin
            cnt_q <= TOP;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP); // R3
    AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (cnt_q == TOP)); // R3
endmodule

// File: rtl/cardpwr_gate.sv
module cardpwr_gate
    import cpg_pkg::*;
#(
    parameter int STAB_CYCLES = 2_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req_i,
    input  logic card_here_i,
    input  logic host_run_i,
    input  logic vdd_fault_i,
    input  logic vcc_fault_i,
    output logic analog_off_o,
    output logic act_o,
    output logic deact_o,
    output logic irq_o
);
    logic [IN_W-1:0] raw_in;
    logic [IN_W-1:0] syn;
    logic            run_prev_q;
    logic            run_rise;
    logic            run_fall;
    logic            fault_s;
    logic            win_done;
    logic            end_q;
    cpg_state_t      state_q;
    cpg_state_t      state_d;

    assign raw_in[I_PD]   = pd_req_i;
    assign raw_in[I_RUN]  = host_run_i;
    assign raw_in[I_CARD] = card_here_i;
    assign raw_in[I_VDDF] = vdd_fault_i;
    assign raw_in[I_VCCF] = vcc_fault_i;

    cpg_sync #(.W(IN_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn)
    );

    cpg_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload_i  (state_q != ST_WAKE),
        .expired_o (win_done)
    );

    assign run_rise = syn[I_RUN] & ~run_prev_q;
    assign run_fall = ~syn[I_RUN] & run_prev_q;
    assign fault_s  = syn[I_VDDF] | syn[I_VCCF];

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DOWN: if (!syn[I_PD]) state_d = ST_WAKE;
            ST_WAKE: begin
                if (syn[I_PD])     state_d = ST_DOWN;
                else if (win_done) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (syn[I_PD])                 state_d = ST_DOWN;
                else if (run_rise && !fault_s) state_d = ST_LIVE;
            end
            ST_LIVE: if (fault_s || run_fall) state_d = ST_IDLE;
            default: state_d = ST_WAKE;
        endcase
    end

    // state register and edge / end-of-session flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_WAKE;
            run_prev_q <= 1'b0;
            end_q      <= 1'b0;
        end else begin
            state_q    <= state_d;
            run_prev_q <= syn[I_RUN];
            end_q      <= (state_q == ST_LIVE) && (state_d != ST_LIVE);
        end
    end

    // outputs
    always_comb begin
        analog_off_o = (state_q == ST_DOWN);
        act_o        = (state_q == ST_LIVE);
        deact_o      = fault_s | end_q;
        irq_o        = syn[I_CARD] & (state_q != ST_WAKE);
    end

    AST_WAIT_FOR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE && !syn[I_PD] && !win_done) |=> (state_q == ST_WAKE)); // R3
    AST_NO_START_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOWN || state_q == ST_WAKE) |=> (state_q != ST_LIVE)); // R4
    AST_NO_SLEEP_IN_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LIVE) |=> !analog_off_o); // R9
    AST_FAULT_ENDS_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_s && state_q == ST_LIVE) |=> !act_o); // R8
    AST_FAULT_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_s && state_q != ST_LIVE) |=> !act_o); // R8
    AST_END_HAS_DEACT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act_o) |-> deact_o); // R7
endmodule

// File: tb/cardpwr_gate_test.sv
`timescale 1ns/1ps
module cardpwr_gate_test;
    localparam int STAB = 20;
    localparam int LIMIT = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd = 1'b0, card = 1'b0, run = 1'b0, vddf = 1'b0, vccf = 1'b0;
    logic analog_off_o, act_o, deact_o, irq_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    cardpwr_gate #(.STAB_CYCLES(STAB)) uut (
        .clk(clk), .rst_n(rst_n), .pd_req_i(pd), .card_here_i(card),
        .host_run_i(run), .vdd_fault_i(vddf), .vcc_fault_i(vccf),
        .analog_off_o(analog_off_o), .act_o(act_o), .deact_o(deact_o), .irq_o(irq_o)
    );

    // behavioural reference: mode 0 asleep, 1 settling, 2 ready, 3 session
    int m_mode = 1;
    int m_left = STAB - 1;
    bit m_prev = 1'b0, m_endp = 1'b0;
    bit m_a[5];
    bit m_b[5];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 1; m_left = STAB - 1; m_prev = 0; m_endp = 0;
            foreach (m_a[i]) begin m_a[i] = 0; m_b[i] = 0; end
        end else begin
            int nxt;
            bit flt;
            flt = m_b[3] | m_b[4];
            nxt = m_mode;
            if (m_mode == 0) begin
                if (!m_b[0]) nxt = 1;
            end else if (m_mode == 1) begin
                if (m_b[0]) nxt = 0; else if (m_left == 0) nxt = 2;
            end else if (m_mode == 2) begin
                if (m_b[0]) nxt = 0; else if (m_b[1] && !m_prev && !flt) nxt = 3;
            end else begin
                if (flt || (!m_b[1] && m_prev)) nxt = 2;
            end
            m_endp = (m_mode == 3) && (nxt != 3);
            if (m_mode != 1) m_left = STAB - 1;
            else if (m_left > 0) m_left--;
            m_prev = m_b[1];
            m_b = m_a;
            m_a[0] = pd; m_a[1] = run; m_a[2] = card; m_a[3] = vddf; m_a[4] = vccf;
            m_mode = nxt;
        end
    end

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0b expected %0b at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (!done) begin
            chk("R2 analog_off_o model", analog_off_o, m_mode == 0);
            chk("R6 act_o model", act_o, m_mode == 3);
            chk("R7 deact_o model", deact_o, m_b[3] | m_b[4] | m_endp);
            chk("R10 irq_o model", irq_o, m_b[2] && m_mode != 1);
        end
        if (cycles > LIMIT && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL R1 watchdog cycles %0d expected below %0d", cycles, LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        card = 1'b1;
        step(3);
        chk("R1 reset analog_off_o", analog_off_o, 1'b0);
        chk("R1 reset act_o", act_o, 1'b0);
        chk("R1 reset deact_o", deact_o, 1'b0);
        rst_n = 1'b1;
        step(5);
        chk("R1 irq_o low in window", irq_o, 1'b0);
        run = 1'b1;                         // early request, dropped
        step(30);
        chk("R5 held level no start", act_o, 1'b0);
        chk("R10 ready irq_o", irq_o, 1'b1);
        run = 1'b0; step(3);
        run = 1'b1; step(2);
        chk("R6 act_o not yet", act_o, 1'b0);
        step(1);
        chk("R6 act_o third edge", act_o, 1'b1);
        run = 1'b0; step(3);
        chk("R7 act_o cleared", act_o, 1'b0);
        chk("R7 deact_o pulse", deact_o, 1'b1);
        step(1);
        chk("R7 deact_o one cycle", deact_o, 1'b0);
        run = 1'b1; step(4);
        pd = 1'b1; step(10);
        chk("R9 no sleep in session", analog_off_o, 1'b0);
        chk("R9 session kept", act_o, 1'b1);
        run = 1'b0; step(6);
        chk("R9 sleep after end", analog_off_o, 1'b1);
        chk("R2 asleep", analog_off_o, 1'b1);
        card = 1'b0; step(4);
        chk("R10 irq_o no card asleep", irq_o, 1'b0);
        card = 1'b1; step(4);
        chk("R10 irq_o card asleep", irq_o, 1'b1);
        run = 1'b1; step(5);
        chk("R4 edge asleep dropped", act_o, 1'b0);
        pd = 1'b0; step(10);
        pd = 1'b1; step(4);
        chk("R3 back to sleep", analog_off_o, 1'b1);
        pd = 1'b0; step(19);
        chk("R3 full window reloaded", irq_o, 1'b0);
        step(6);
        chk("R3 window over", irq_o, 1'b1);
        chk("R5 high level at close", act_o, 1'b0);
        run = 1'b0; step(4);
        run = 1'b1; step(4);
        chk("R6 session up", act_o, 1'b1);
        vccf = 1'b1; step(2);
        chk("R8 deact_o on fault", deact_o, 1'b1);
        step(1);
        chk("R8 fault ends session", act_o, 1'b0);
        run = 1'b0; step(3);
        run = 1'b1; step(5);
        chk("R8 start blocked", act_o, 1'b0);
        vccf = 1'b0; step(4);
        run = 1'b0; step(3);
        run = 1'b1; step(4);
        chk("R6 session again", act_o, 1'b1);
        vddf = 1'b1; run = 1'b0;            // fault and falling edge together
        step(4);
        chk("R8 collision act_o", act_o, 1'b0);
        chk("R8 collision deact_o", deact_o, 1'b1);
        vddf = 1'b0; step(5);
        chk("R8 fault gone", deact_o, 1'b0);
        pd = 1'b1; run = 1'b1;              // request and edge together
        step(5);
        chk("R4 sleep wins", analog_off_o, 1'b1);
        chk("R4 edge lost", act_o, 1'b0);
        step(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule